// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block sits beside one small direct-mapped cache and keeps a four-state MESI tag for every line. The local processor issues loads and stores. Loads that hit, and stores that hit a line this cache may already modify, finish in the same cycle. Anything else becomes a request on a shared single-cycle bus. The possible requests are a plain read, a read for ownership, an upgrade that invalidates other copies, and a writeback of a dirty victim. The processor stalls until the request is granted. Grant and data phase are the same cycle: memory or a peer supplies the fill word and the wired-OR shared answer then.

The controller also watches the transactions that other caches put on the bus. When a snooped address is held, it answers that it holds a copy. It supplies and flushes the word if the line is dirty, and it moves the line to Shared or Invalid as the protocol requires. A store to a line held as the only clean copy becomes dirty without any bus traffic. That state is only granted on a read fill when no peer answered "shared". A snoop takes priority over a local request to the same line. The local request is withheld for that cycle and is decided afresh against the new line state.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req`, `cpu_ready`, `snp_shared` and `snp_flush` are low, and the first access to any address goes to the bus.
- R2: A load miss issues a read (`bus_cmd` = 1). The line fills as Exclusive if `bus_shared_in` is low in the grant cycle and as Shared if it is high; a later store shows which state was chosen.
- R3: A store that hits an Exclusive line completes with `cpu_ready` in one cycle, makes the line Modified, and raises no `bus_req`.
- R4: A store that hits a Shared line first issues an upgrade (`bus_cmd` = 3) for the store address, then completes the store as a hit on the now Modified line.
- R5: A store miss issues a read-exclusive (`bus_cmd` = 2) and installs the line as Modified with the stored word.
- R6: A snooped read-exclusive (`snp_cmd` = 2) or upgrade (`snp_cmd` = 3) that hits a valid line makes it Invalid, so the next local access to it misses.
- R7: A snooped read (`snp_cmd` = 1) that hits a Modified or Exclusive line leaves it Shared, so a later local store needs an upgrade.
- R8: In the cycle a snooped read or read-exclusive is presented, `snp_shared` is high exactly when this cache holds a valid copy of that address.
- R9: Before refilling over a Modified line of a different tag, the controller issues a writeback (`bus_cmd` = 4) carrying the victim address and word. Shared or Exclusive victims are dropped with no bus traffic.
- R10: A snooped read or read-exclusive that hits a Modified line raises `snp_flush` and drives the line's word on `snp_data` in the same cycle. Otherwise `snp_flush` is low and `snp_data` is zero.
- R11: Load hits, and store hits in Modified or Exclusive, raise `cpu_ready` in the request cycle with `bus_req` low. A request that needs the bus holds `bus_req` and `bus_cmd` steady until `bus_gnt`, with `cpu_ready` low.
- R12: While a snoop is presented to the same index as the local request, neither `cpu_ready` nor `bus_req` is raised. Afterwards the request is decided again from the updated line state.
- R13: `bus_cmd` is 0 whenever `bus_req` is low. `bus_addr` is the request address for read, read-exclusive and upgrade, and `bus_wdata` is zero except during a writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Local access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access completes this cycle |
| bus_req | output | 1 | Bus transaction wanted |
| bus_gnt | input | 1 | Grant; the transaction happens in this cycle |
| bus_cmd | output | 3 | 0 idle, 1 read, 2 read-exclusive, 3 upgrade, 4 writeback |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback word |
| bus_rdata | input | DATA_W | Fill word in the grant cycle |
| bus_shared_in | input | 1 | Wired-OR shared answer of the other caches |
| snp_valid | input | 1 | A foreign transaction is on the bus |
| snp_cmd | input | 3 | Its command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Its address |
| snp_shared | output | 1 | This cache holds a copy (wired-OR contribution) |
| snp_flush | output | 1 | This cache supplies dirty data and writes it back |
| snp_data | output | DATA_W | Supplied word |

## Verification
The bench builds the block with its defaults: 8-bit addresses, 8-bit words and two index bits, so four lines. With only four lines, two addresses that differ in their upper bits collide in a handful of accesses. That makes dirty and clean evictions, and snoops that miss on a tag while hitting an index, easy to set up. The bench acts as bus and memory itself. It can withhold grant, which holds a request pending while a conflicting snoop arrives and shows the upgrade turning into a read-exclusive.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_e;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_RD   = 3'd1,
    CMD_RDX  = 3'd2,
    CMD_UPG  = 3'd3,
    CMD_WB   = 3'd4
  } bus_cmd_e;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  // local port
  input  logic [IDX_W-1:0]  l_idx,
  input  logic              l_st_we,
  input  mesi_e             l_st,
  input  logic              l_tag_we,
  input  logic [TAG_W-1:0]  l_tag,
  input  logic              l_data_we,
  input  logic [DATA_W-1:0] l_data,
  output mesi_e             l_st_o,
  output logic [TAG_W-1:0]  l_tag_o,
  output logic [DATA_W-1:0] l_data_o,
  // snoop port
  input  logic [IDX_W-1:0]  s_idx,
  input  logic              s_st_we,
  input  mesi_e             s_st,
  output mesi_e             s_st_o,
  output logic [TAG_W-1:0]  s_tag_o,
  output logic [DATA_W-1:0] s_data_o,
  // state of every line
  output mesi_e             st_vec [LINES]
);

  mesi_e             st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    mesi_e st_d;
    logic  l_sel, s_sel;

    assign l_sel = (l_idx == MY_IDX);
    assign s_sel = (s_idx == MY_IDX);

    // snoop update wins over a local update of the same line
    always_comb begin
      st_d = st_q[g];
      if (l_sel && l_st_we) st_d = l_st;
      if (s_sel && s_st_we) st_d = s_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[g] <= ST_I;
      else        st_q[g] <= st_d;
    end

    always_ff @(posedge clk) begin
      if (l_sel && l_tag_we)  tag_q[g]  <= l_tag;
      if (l_sel && l_data_we) data_q[g] <= l_data;
    end

    assign st_vec[g] = st_q[g];
  end

  assign l_st_o   = st_q[l_idx];
  assign l_tag_o  = tag_q[l_idx];
  assign l_data_o = data_q[l_idx];
  assign s_st_o   = st_q[s_idx];
  assign s_tag_o  = tag_q[s_idx];
  assign s_data_o = data_q[s_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              snp_valid,
  input  bus_cmd_e          snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  mesi_e             line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              shared_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] data_o,
  output logic              st_we_o,
  output mesi_e             st_o
);

  logic hit, is_rd, is_rdx, is_upg;

  always_comb begin
    hit    = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
    is_rd  = (snp_cmd == CMD_RD);
    is_rdx = (snp_cmd == CMD_RDX);
    is_upg = (snp_cmd == CMD_UPG);

    shared_o = hit && (is_rd || is_rdx);
    flush_o  = hit && (line_st == ST_M) && (is_rd || is_rdx);
    data_o   = flush_o ? line_data : '0;

    st_we_o = hit && (is_rd || is_rdx || is_upg);
    st_o    = is_rd ? ST_S : ST_I;
  end

endmodule

// File: rtl/mesi_local_unit.sv
module mesi_local_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [TAG_W-1:0]  cpu_tag,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              conflict,
  input  mesi_e             line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic              bus_gnt,
  input  logic              bus_shared,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              ready_o,
  output logic              bus_req_o,
  output bus_cmd_e          bus_cmd_o,
  output logic              victim_o,
  output logic              st_we_o,
  output mesi_e             st_o,
  output logic              tag_we_o,
  output logic              data_we_o,
  output logic [DATA_W-1:0] data_o
);

  logic     active, hit, done_hit;
  bus_cmd_e need;
  logic     granted;

  always_comb begin
    active   = cpu_req && !conflict;
    hit      = (line_st != ST_I) && (line_tag == cpu_tag);
    done_hit = hit && (!cpu_we || line_st == ST_M || line_st == ST_E);

    need = CMD_NONE;
    if (active && !done_hit) begin
      if (hit)                 need = CMD_UPG;
      else if (line_st == ST_M) need = CMD_WB;
      else if (cpu_we)         need = CMD_RDX;
      else                     need = CMD_RD;
    end

    ready_o   = active && done_hit;
    bus_req_o = (need != CMD_NONE);
    bus_cmd_o = need;
    victim_o  = (need == CMD_WB);
    granted   = bus_req_o && bus_gnt;

    st_we_o   = 1'b0;
    st_o      = line_st;
    tag_we_o  = 1'b0;
    data_we_o = 1'b0;
    data_o    = cpu_wdata;

    if (ready_o && cpu_we) begin
      st_we_o   = 1'b1;
      st_o      = ST_M;
      data_we_o = 1'b1;
    end else if (granted) begin
      unique case (need)
        CMD_UPG: begin
          st_we_o = 1'b1;
          st_o    = ST_M;
        end
        CMD_WB: begin
          st_we_o = 1'b1;
          st_o    = ST_I;
        end
        CMD_RD, CMD_RDX: begin
          st_we_o   = 1'b1;
          st_o      = (need == CMD_RDX) ? ST_M : (bus_shared ? ST_S : ST_E);
          tag_we_o  = 1'b1;
          data_we_o = 1'b1;
          data_o    = bus_rdata;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 8,
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [2:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);

  // reset: asserted at once, released on the clock
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic [IDX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0] c_tag, s_tag;
  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];

  mesi_e             l_st, s_st;
  logic [TAG_W-1:0]  l_tag, s_line_tag;
  logic [DATA_W-1:0] l_data, s_line_data;
  mesi_e             st_vec [LINES];

  logic              u_st_we, u_tag_we, u_data_we, victim;
  mesi_e             u_st;
  logic [DATA_W-1:0] u_data;
  bus_cmd_e          cmd_e;
  logic              sn_st_we;
  mesi_e             sn_st;
  logic              conflict;

  assign conflict = snp_valid && (s_idx == c_idx);

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_q),
    .l_idx     (c_idx),
    .l_st_we   (u_st_we),
    .l_st      (u_st),
    .l_tag_we  (u_tag_we),
    .l_tag     (c_tag),
    .l_data_we (u_data_we),
    .l_data    (u_data),
    .l_st_o    (l_st),
    .l_tag_o   (l_tag),
    .l_data_o  (l_data),
    .s_idx     (s_idx),
    .s_st_we   (sn_st_we),
    .s_st      (sn_st),
    .s_st_o    (s_st),
    .s_tag_o   (s_line_tag),
    .s_data_o  (s_line_data),
    .st_vec    (st_vec)
  );

  mesi_local_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_local (
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_tag    (c_tag),
    .cpu_wdata  (cpu_wdata),
    .conflict   (conflict),
    .line_st    (l_st),
    .line_tag   (l_tag),
    .bus_gnt    (bus_gnt),
    .bus_shared (bus_shared_in),
    .bus_rdata  (bus_rdata),
    .ready_o    (cpu_ready),
    .bus_req_o  (bus_req),
    .bus_cmd_o  (cmd_e),
    .victim_o   (victim),
    .st_we_o    (u_st_we),
    .st_o       (u_st),
    .tag_we_o   (u_tag_we),
    .data_we_o  (u_data_we),
    .data_o     (u_data)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid (snp_valid),
    .snp_cmd   (bus_cmd_e'(snp_cmd)),
    .snp_tag   (s_tag),
    .line_st   (s_st),
    .line_tag  (s_line_tag),
    .line_data (s_line_data),
    .shared_o  (snp_shared),
    .flush_o   (snp_flush),
    .data_o    (snp_data),
    .st_we_o   (sn_st_we),
    .st_o      (sn_st)
  );

  assign cpu_rdata = l_data;
  assign bus_cmd   = cmd_e;
  assign bus_addr  = victim ? {l_tag, c_idx} : cpu_addr;
  assign bus_wdata = victim ? l_data : '0;

  // ---------------- assertions ----------------
  assert_fill_excl_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_req && bus_gnt && cmd_e == CMD_RD && !bus_shared_in)
    |=> (st_vec[$past(c_idx)] == ST_E));

  assert_silent_dirty_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_ready && cpu_we) |=> (st_vec[$past(c_idx)] == ST_M));

  assert_excl_store_quiet_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_req && cpu_we && !conflict && l_st == ST_E && l_tag == c_tag) |-> !bus_req);

  assert_rdx_install_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_req && bus_gnt && cmd_e == CMD_RDX) |=> (st_vec[$past(c_idx)] == ST_M));

  assert_snoop_inval_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (snp_valid && (snp_cmd == 3'd2 || snp_cmd == 3'd3) && s_st != ST_I && s_line_tag == s_tag)
    |=> (st_vec[$past(s_idx)] == ST_I));

  assert_snoop_share_R7: assert property (@(posedge clk) disable iff (!rst_q)
    (snp_valid && snp_cmd == 3'd1 && snp_shared) |=> (st_vec[$past(s_idx)] == ST_S));

  assert_flush_dirty_R10: assert property (@(posedge clk) disable iff (!rst_q)
    snp_flush |-> (snp_shared && snp_valid));

  assert_hold_req_R11: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_req && !bus_gnt && !snp_valid && cpu_req && cmd_e != CMD_WB)
    |=> (bus_req || !cpu_req || snp_valid || !$stable(cpu_addr)));

  assert_conflict_stall_R12: assert property (@(posedge clk) disable iff (!rst_q)
    conflict |-> (!cpu_ready && !bus_req));

  assert_idle_cmd_R13: assert property (@(posedge clk) disable iff (!rst_q)
    !bus_req |-> (bus_cmd == 3'd0 && bus_wdata == '0));

endmodule

// File: tb/mesi_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_tb;

  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic          cpu_ready;
  logic          bus_req, bus_gnt;
  logic [2:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          bus_shared_in;
  logic          snp_valid;
  logic [2:0]    snp_cmd;
  logic [AW-1:0] snp_addr;
  logic          snp_shared, snp_flush;
  logic [DW-1:0] snp_data;

  logic          gnt_en;
  logic [DW-1:0] mem [256];

  always #2.5 clk = ~clk;

  assign bus_gnt   = bus_req && gnt_en;
  assign bus_rdata = mem[bus_addr];

  mesi_snoop_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_data(snp_data)
  );

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    bit         is_cpu;
    bit         chk_data;
    logic [2:0] cmd;
    logic [7:0] addr;
    logic [7:0] data;
    string      req;
  } item_t;

  item_t sb [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic exp_bus(input logic [2:0] cmd, input logic [7:0] a, input logic [7:0] d,
                         input bit chk, input string req);
    item_t it;
    it.is_cpu = 1'b0; it.cmd = cmd; it.addr = a; it.data = d; it.chk_data = chk; it.req = req;
    sb.push_back(it);
  endtask

  task automatic exp_cpu(input logic [7:0] d, input bit chk, input string req);
    item_t it;
    it.is_cpu = 1'b1; it.cmd = 3'd0; it.addr = '0; it.data = d; it.chk_data = chk; it.req = req;
    sb.push_back(it);
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n && (cpu_ready || (bus_req && bus_gnt))) begin
      if (sb.size() == 0) begin
        check(1'b0, "unexpected event R11", {bus_cmd, 5'd0}, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (it.is_cpu) begin
          check(cpu_ready, {it.req, " kind"}, bus_cmd, 0);
          if (cpu_ready && it.chk_data) check(cpu_rdata == it.data, it.req, cpu_rdata, it.data);
        end else begin
          check(bus_req && bus_gnt && bus_cmd == it.cmd && bus_addr == it.addr,
                it.req, {bus_cmd, bus_addr}, {it.cmd, it.addr});
          if (it.chk_data) check(bus_wdata == it.data, it.req, bus_wdata, it.data);
        end
      end
      if (bus_req && bus_gnt && bus_cmd == 3'd4) mem[bus_addr] = bus_wdata;
    end
  end

  task automatic cpu_access(input bit we, input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    do @(negedge clk); while (!cpu_ready);
    @(posedge clk); #1;
    cpu_req = 1'b0;
  endtask

  task automatic snoop(input logic [2:0] cmd, input logic [7:0] a, input bit e_sh,
                       input bit e_fl, input logic [7:0] e_d, input string req);
    @(posedge clk); #1;
    snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
    @(negedge clk);
    check(snp_shared == e_sh, {req, " shared"}, snp_shared, e_sh);
    check(snp_flush == e_fl, {req, " flush"}, snp_flush, e_fl);
    check(snp_data == (e_fl ? e_d : 8'h00), {req, " data"}, snp_data, e_fl ? e_d : 8'h00);
    if (snp_flush) mem[a] = snp_data;
    @(posedge clk); #1;
    snp_valid = 1'b0; snp_cmd = 3'd0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 3 + 1);
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    bus_shared_in = 1'b0; snp_valid = 1'b0; snp_cmd = '0; snp_addr = '0; gnt_en = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!bus_req && !cpu_ready && !snp_shared && !snp_flush, "R1 reset outputs",
          {bus_req, cpu_ready, snp_shared, snp_flush}, 0);

    // R1 R2: cold read miss, no sharer -> Exclusive
    exp_bus(3'd1, 8'h10, 0, 0, "R1 R2 read miss");
    exp_cpu(mem[8'h10], 1, "R2 fill data");
    cpu_access(0, 8'h10, 0);
    // R3: store to Exclusive, no bus
    exp_cpu(0, 0, "R3 silent store");
    cpu_access(1, 8'h10, 8'hA5);
    exp_cpu(8'hA5, 1, "R11 hit in M");
    cpu_access(0, 8'h10, 0);
    // R10 R7: snooped read on Modified
    snoop(3'd1, 8'h10, 1, 1, 8'hA5, "R10 snoop rd M");
    // R4: store on Shared needs upgrade
    exp_bus(3'd3, 8'h10, 0, 0, "R4 upgrade");
    exp_cpu(0, 0, "R4 store done");
    cpu_access(1, 8'h10, 8'h3C);
    // R6 R10: snooped read-exclusive on M
    snoop(3'd2, 8'h10, 1, 1, 8'h3C, "R6 snoop rdx M");
    bus_shared_in = 1'b1;
    exp_bus(3'd1, 8'h10, 0, 0, "R6 miss after invalidate");
    exp_cpu(8'h3C, 1, "R6 refetched data");
    cpu_access(0, 8'h10, 0);
    bus_shared_in = 1'b0;
    // R2: shared fill -> store needs upgrade
    exp_bus(3'd3, 8'h10, 0, 0, "R2 shared fill state");
    exp_cpu(0, 0, "R2 store done");
    cpu_access(1, 8'h10, 8'h77);
    // R5: write miss
    exp_bus(3'd2, 8'h21, 0, 0, "R5 read-exclusive");
    exp_cpu(0, 0, "R5 store done");
    cpu_access(1, 8'h21, 8'h44);
    snoop(3'd1, 8'h21, 1, 1, 8'h44, "R5 installed M");
    // R9: dirty eviction
    exp_bus(3'd2, 8'h22, 0, 0, "R9 setup rdx");
    exp_cpu(0, 0, "R9 setup store");
    cpu_access(1, 8'h22, 8'h99);
    exp_bus(3'd4, 8'h22, 8'h99, 1, "R9 writeback");
    exp_bus(3'd1, 8'h26, 0, 0, "R9 refill");
    exp_cpu(mem[8'h26], 1, "R9 refill data");
    cpu_access(0, 8'h26, 0);
    check(mem[8'h22] == 8'h99, "R9 memory updated", mem[8'h22], 8'h99);
    // R9: clean eviction silent
    exp_bus(3'd1, 8'h03, 0, 0, "R9 clean setup");
    exp_cpu(mem[8'h03], 1, "R9 clean data");
    cpu_access(0, 8'h03, 0);
    exp_bus(3'd1, 8'h07, 0, 0, "R9 silent drop");
    exp_cpu(mem[8'h07], 1, "R9 silent data");
    cpu_access(0, 8'h07, 0);
    // R7: snooped read on Exclusive
    snoop(3'd1, 8'h07, 1, 0, 0, "R7 snoop rd E");
    exp_bus(3'd3, 8'h07, 0, 0, "R7 now shared");
    exp_cpu(0, 0, "R7 store done");
    cpu_access(1, 8'h07, 8'h12);
    // R8: snoops that miss on tag
    snoop(3'd1, 8'h0B, 0, 0, 0, "R8 tag miss rd");
    snoop(3'd2, 8'h04, 0, 0, 0, "R8 tag miss rdx");
    exp_cpu(8'h77, 1, "R8 line untouched");
    cpu_access(0, 8'h10, 0);
    // R6: snooped upgrade on Shared
    snoop(3'd1, 8'h07, 1, 1, 8'h12, "R7 downgrade M");
    snoop(3'd3, 8'h07, 0, 0, 0, "R6 snoop upgrade");
    exp_bus(3'd1, 8'h07, 0, 0, "R6 miss after upgrade");
    exp_cpu(8'h12, 1, "R6 data");
    cpu_access(0, 8'h07, 0);
    // R11 R12: pending upgrade overtaken by a snooped read-exclusive
    gnt_en = 1'b0;
    exp_bus(3'd2, 8'h21, 0, 0, "R12 re-evaluated to rdx");
    exp_cpu(0, 0, "R12 store done");
    fork
      cpu_access(1, 8'h21, 8'h55);
      begin
        repeat (3) @(negedge clk);
        check(bus_req && bus_cmd == 3'd3 && !cpu_ready, "R11 stall holds upgrade",
              {bus_req, bus_cmd}, {1'b1, 3'd3});
        @(posedge clk); #1;
        snp_valid = 1'b1; snp_cmd = 3'd2; snp_addr = 8'h21;
        @(negedge clk);
        check(!bus_req && !cpu_ready, "R12 withheld during snoop", {bus_req, cpu_ready}, 0);
        check(snp_shared && !snp_flush, "R8 shared on S", {snp_shared, snp_flush}, 2);
        @(posedge clk); #1;
        snp_valid = 1'b0; snp_cmd = 3'd0;
        gnt_en = 1'b1;
      end
    join
    repeat (3) @(posedge clk);
    check(sb.size() == 0, "R11 all events seen", sb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule